// File: doc/BRIEF.md
# Security-Masked Private Interrupt Register Bank

This block keeps the per-processor configuration and state of 32 private interrupts: sixteen software-generated ones (numbers 0 to 15) and sixteen peripheral ones (16 to 31). Software reaches it over a plain register bus that carries byte, word and doubleword accesses. Each access is tagged secure or non-secure. A global `sec_disable` input switches the security checks off. The bank stores a group bitmap, a group modifier bitmap, enable, pending and active bitmaps (each reached through a set address and a clear address), one priority byte per interrupt, edge/level trigger flags, a non-secure access-control word and a sleep request with its status. All of this state is exported on output ports for the prioritisation logic, which lives outside the block.

"Restricted view" in this brief means security is enabled (`sec_disable`=0) and the access is non-secure. In that view, only interrupts whose group bit is 1 can be seen or changed, and their priorities are shown through a scaled view. Every access gets exactly one response, and no access raises a bus error.

Top module: `pirq_regbank`

## Requirements
- R1: After reset every stored register and exported state port is zero, and `resp_valid` is low.
- R2: Each request cycle produces `resp_valid` in the next cycle. A read returns its data with that response. A write returns zero data.
- R3: Writing to a set address (enable 0x20, pending 0x28, active 0x30) ORs the masked data into the bitmap. Writing to the matching clear address (0x24, 0x2C, 0x34) clears the bits where the masked data is 1. Both addresses read the same masked value. When one doubleword sets and clears in the same write, the clear takes effect last. Stored state changes only on writes.
- R4: In the restricted view, enable, pending, active and priority bits of interrupts whose group bit is 0 read as zero and ignore writes. When security is disabled, or the access is secure, every interrupt is visible.
- R5: A pending read returns the pending latch ORed with (`irq_level` AND NOT edge flag). An asserted level-sensitive line therefore reads as pending.
- R6: Priority n sits at byte address 0x40+n. A word access at 0x40+4k covers interrupts 4k to 4k+3, with the lowest-numbered interrupt in bits [7:0]. A byte access returns its priority in bits [7:0].
- R7: In the restricted view, for a group-1 interrupt, a priority read returns (stored<<1)&0xFF and a priority write stores 0x80|(data>>1).
- R8: The word at 0x38 holds the trigger flags of interrupts 0-15, and the word at 0x3C holds those of 16-31. The edge flag of the n-th interrupt in a word is bit 2n+1, and the even bits read zero. Writes to 0x38 are ignored. Writes to 0x3C change only the flags that the R4 mask permits.
- R9: The group word (0x10) reads as zero and ignores writes in the restricted view. The group modifier word (0x14) and the access-control word (0x18) are accessible only when security is enabled and the access is secure; otherwise they read as zero and ignore writes.
- R10: In the wake word (0x00), bit 0 is the sleep request and is the only writable bit. Bit 1 (asleep status) takes the same value in the same write.
- R11: Unimplemented offsets, misaligned accesses, size code 3, and byte accesses outside the priority range all read as zero and ignore writes.
- R12: A doubleword access (size 2, 8-byte aligned) acts as two word accesses. The low word goes to the addressed register and the high word to the register at address+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_disable | input | 1 | 1 turns off all security masking |
| irq_level | input | 32 | Current level of each interrupt line |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 doubleword |
| req_addr | input | ADDR_W | Byte offset within the bank |
| req_wdata | input | 64 | Write data (a byte access uses bits [7:0]) |
| req_secure | input | 1 | 1 = secure access |
| resp_valid | output | 1 | Response, one cycle after the request |
| resp_rdata | output | 64 | Read data |
| st_group | output | 32 | Group bitmap |
| st_grpmod | output | 32 | Group modifier bitmap |
| st_nsacr | output | 32 | Non-secure access-control word |
| st_enable | output | 32 | Enable bitmap |
| st_pending | output | 32 | Pending latch |
| st_active | output | 32 | Active bitmap |
| st_edge | output | 32 | Edge-trigger flags, one per interrupt |
| st_prio | output | 256 | Priority bytes, interrupt n at [8n+7:8n] |
| st_sleep | output | 1 | Sleep request |
| st_asleep | output | 1 | Asleep status |

## Verification
Read data comes out on `resp_rdata` in the cycle after the request, and a write is reflected on the `st_*` ports in that same next cycle. The driver presents each request at a falling edge. It pushes the expected response into a queue, and a monitor pops the queue at the following falling edge, so every compare lands exactly one cycle after its request. Direct checks on the state ports are made only after the queue has drained, at least one full cycle after the last write.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int NIRQ   = 32;
  localparam int NHALF  = NIRQ / 2;
  localparam int PRIO_W = 8;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  localparam logic [31:0] OFF_WAKE   = 32'h00;
  localparam logic [31:0] OFF_GROUP  = 32'h10;
  localparam logic [31:0] OFF_GRPMOD = 32'h14;
  localparam logic [31:0] OFF_NSACR  = 32'h18;
  localparam logic [31:0] OFF_EN_S   = 32'h20;
  localparam logic [31:0] OFF_EN_C   = 32'h24;
  localparam logic [31:0] OFF_PD_S   = 32'h28;
  localparam logic [31:0] OFF_PD_C   = 32'h2C;
  localparam logic [31:0] OFF_AC_S   = 32'h30;
  localparam logic [31:0] OFF_AC_C   = 32'h34;
  localparam logic [31:0] OFF_CFG_LO = 32'h38;
  localparam logic [31:0] OFF_CFG_HI = 32'h3C;
  localparam logic [31:0] OFF_PRIO   = 32'h40;

  typedef struct packed {
    logic [NIRQ-1:0]        group;
    logic [NIRQ-1:0]        grpmod;
    logic [31:0]            nsacr;
    logic [NIRQ-1:0]        enable;
    logic [NIRQ-1:0]        pending;
    logic [NIRQ-1:0]        active;
    logic [NIRQ-1:0]        trig_edge;
    logic [NIRQ*PRIO_W-1:0] prio;
    logic                   sleep;
    logic                   asleep;
  } bank_t;

  typedef struct packed {
    logic                   grp_we;
    logic [NIRQ-1:0]        grp_d;
    logic                   grpmod_we;
    logic [NIRQ-1:0]        grpmod_d;
    logic                   nsacr_we;
    logic [31:0]            nsacr_d;
    logic [NIRQ-1:0]        en_set;
    logic [NIRQ-1:0]        en_clr;
    logic [NIRQ-1:0]        pd_set;
    logic [NIRQ-1:0]        pd_clr;
    logic [NIRQ-1:0]        ac_set;
    logic [NIRQ-1:0]        ac_clr;
    logic [NHALF-1:0]       cfg_mask;
    logic [NHALF-1:0]       cfg_val;
    logic                   wake_we;
    logic                   wake_d;
    logic [NIRQ-1:0]        prio_we;
    logic [NIRQ*PRIO_W-1:0] prio_d;
  } upd_t;

  // Non-secure view of a stored priority
  function automatic logic [7:0] ns_prio_view(input logic [7:0] stored);
    return {stored[6:0], 1'b0};
  endfunction

  // Value stored when a non-secure agent writes a priority
  function automatic logic [7:0] ns_prio_store(input logic [7:0] data);
    return {1'b1, data[7:1]};
  endfunction

  // Place 16 flags on the odd bits of a word
  function automatic logic [31:0] spread_odd(input logic [15:0] flags);
    logic [31:0] w;
    w = '0;
    for (int n = 0; n < 16; n++) w[2*n+1] = flags[n];
    return w;
  endfunction

  // Collect the odd bits of a word into 16 flags
  function automatic logic [15:0] gather_odd(input logic [31:0] w);
    logic [15:0] f;
    for (int n = 0; n < 16; n++) f[n] = w[2*n+1];
    return f;
  endfunction

endpackage

// File: rtl/pirq_lane.sv
module pirq_lane
  import pirq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              active,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        ben,
  input  logic [31:0]       wdata,
  input  logic              ns_view,
  input  logic              sec_priv,
  input  bank_t             st,
  input  logic [NIRQ-1:0]   level,
  output logic [31:0]       rdata,
  output upd_t              upd
);

  localparam int PRIO_SPAN = NIRQ;

  logic [31:0]     off;
  logic [NIRQ-1:0] gmask;
  logic            full;
  logic            in_prio;
  logic [4:0]      pbase;

  assign off     = 32'(addr);
  assign gmask   = ns_view ? st.group : '1;
  assign full    = (ben == 4'hF);
  assign in_prio = (off >= OFF_PRIO) && (off < OFF_PRIO + PRIO_SPAN);
  assign pbase   = 5'(off - OFF_PRIO);

  always_comb begin
    int k;
    logic [7:0] pv;
    upd   = '0;
    rdata = '0;
    k     = 0;
    pv    = '0;
    if (active) begin
      if (in_prio) begin
        for (int b = 0; b < 4; b++) begin
          k  = int'(pbase) + b;
          pv = st.prio[PRIO_W*k +: PRIO_W];
          if (ben[b]) begin
            if (!ns_view) begin
              rdata[8*b +: 8] = pv;
              if (is_write) begin
                upd.prio_we[k] = 1'b1;
                upd.prio_d[PRIO_W*k +: PRIO_W] = wdata[8*b +: 8];
              end
            end else if (st.group[k]) begin
              rdata[8*b +: 8] = ns_prio_view(pv);
              if (is_write) begin
                upd.prio_we[k] = 1'b1;
                upd.prio_d[PRIO_W*k +: PRIO_W] = ns_prio_store(wdata[8*b +: 8]);
              end
            end
          end
        end
      end else if (full) begin
        case (off)
          OFF_WAKE: begin
            rdata[1:0] = {st.asleep, st.sleep};
            upd.wake_we = is_write;
            upd.wake_d  = wdata[0];
          end
          OFF_GROUP: if (!ns_view) begin
            rdata      = st.group;
            upd.grp_we = is_write;
            upd.grp_d  = wdata;
          end
          OFF_GRPMOD: if (sec_priv) begin
            rdata         = st.grpmod;
            upd.grpmod_we = is_write;
            upd.grpmod_d  = wdata;
          end
          OFF_NSACR: if (sec_priv) begin
            rdata        = st.nsacr;
            upd.nsacr_we = is_write;
            upd.nsacr_d  = wdata;
          end
          OFF_EN_S, OFF_EN_C: begin
            rdata = st.enable & gmask;
            if (is_write && off == OFF_EN_S) upd.en_set = wdata & gmask;
            if (is_write && off == OFF_EN_C) upd.en_clr = wdata & gmask;
          end
          OFF_PD_S, OFF_PD_C: begin
            rdata = (st.pending | (level & ~st.trig_edge)) & gmask;
            if (is_write && off == OFF_PD_S) upd.pd_set = wdata & gmask;
            if (is_write && off == OFF_PD_C) upd.pd_clr = wdata & gmask;
          end
          OFF_AC_S, OFF_AC_C: begin
            rdata = st.active & gmask;
            if (is_write && off == OFF_AC_S) upd.ac_set = wdata & gmask;
            if (is_write && off == OFF_AC_C) upd.ac_clr = wdata & gmask;
          end
          OFF_CFG_LO: rdata = spread_odd(st.trig_edge[NHALF-1:0] & gmask[NHALF-1:0]);
          OFF_CFG_HI: begin
            rdata = spread_odd(st.trig_edge[NIRQ-1:NHALF] & gmask[NIRQ-1:NHALF]);
            if (is_write) begin
              upd.cfg_mask = gmask[NIRQ-1:NHALF];
              upd.cfg_val  = gather_odd(wdata);
            end
          end
          default: rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/pirq_regbank.sv
module pirq_regbank
  import pirq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sec_disable,
  input  logic [NIRQ-1:0]        irq_level,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [1:0]             req_size,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [63:0]            req_wdata,
  input  logic                   req_secure,
  output logic                   resp_valid,
  output logic [63:0]            resp_rdata,
  output logic [NIRQ-1:0]        st_group,
  output logic [NIRQ-1:0]        st_grpmod,
  output logic [31:0]            st_nsacr,
  output logic [NIRQ-1:0]        st_enable,
  output logic [NIRQ-1:0]        st_pending,
  output logic [NIRQ-1:0]        st_active,
  output logic [NIRQ-1:0]        st_edge,
  output logic [NIRQ*PRIO_W-1:0] st_prio,
  output logic                   st_sleep,
  output logic                   st_asleep
);

  localparam int NLANE = 2;

  bank_t st;
  upd_t  upd   [NLANE];
  logic [31:0]       lrdata [NLANE];
  logic [ADDR_W-1:0] laddr  [NLANE];
  logic [3:0]        lben   [NLANE];
  logic [31:0]       lwdata [NLANE];
  logic              lact   [NLANE];

  // Named events for the checker
  logic wr_fire, ns_view, sec_priv, align_ok, is_byte, is_dword;

  assign ns_view  = !sec_disable && !req_secure;
  assign sec_priv = !sec_disable && req_secure;
  assign is_byte  = (req_size == SZ_BYTE);
  assign is_dword = (req_size == SZ_DWORD);
  assign wr_fire  = req_valid && req_write;

  always_comb begin
    case (req_size)
      SZ_BYTE:  align_ok = 1'b1;
      SZ_WORD:  align_ok = (req_addr[1:0] == 2'b00);
      SZ_DWORD: align_ok = (req_addr[2:0] == 3'b000);
      default:  align_ok = 1'b0;
    endcase
  end

  assign laddr[0]  = {req_addr[ADDR_W-1:2], 2'b00};
  assign laddr[1]  = laddr[0] + ADDR_W'(4);
  assign lben[0]   = is_byte ? (4'b0001 << req_addr[1:0]) : 4'hF;
  assign lben[1]   = 4'hF;
  assign lwdata[0] = is_byte ? {4{req_wdata[7:0]}} : req_wdata[31:0];
  assign lwdata[1] = req_wdata[63:32];
  assign lact[0]   = req_valid && align_ok;
  assign lact[1]   = req_valid && align_ok && is_dword;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    pirq_lane #(.ADDR_W(ADDR_W)) u_lane (
      .active   (lact[l]),
      .is_write (req_write),
      .addr     (laddr[l]),
      .ben      (lben[l]),
      .wdata    (lwdata[l]),
      .ns_view  (ns_view),
      .sec_priv (sec_priv),
      .st       (st),
      .level    (irq_level),
      .rdata    (lrdata[l]),
      .upd      (upd[l])
    );
  end

  // Merged set/clear masks from both lanes; clear applies last
  logic [NIRQ-1:0] en_nx, pd_nx, ac_nx;
  assign en_nx = (st.enable  | upd[0].en_set | upd[1].en_set) & ~(upd[0].en_clr | upd[1].en_clr);
  assign pd_nx = (st.pending | upd[0].pd_set | upd[1].pd_set) & ~(upd[0].pd_clr | upd[1].pd_clr);
  assign ac_nx = (st.active  | upd[0].ac_set | upd[1].ac_set) & ~(upd[0].ac_clr | upd[1].ac_clr);

  logic [NHALF-1:0] cfg_m, cfg_v;
  assign cfg_m = upd[0].cfg_mask | upd[1].cfg_mask;
  assign cfg_v = (upd[0].cfg_val & upd[0].cfg_mask) | (upd[1].cfg_val & upd[1].cfg_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st.group     <= '0;
      st.grpmod    <= '0;
      st.nsacr     <= '0;
      st.enable    <= '0;
      st.pending   <= '0;
      st.active    <= '0;
      st.trig_edge <= '0;
      st.sleep     <= 1'b0;
      st.asleep    <= 1'b0;
    end else begin
      st.enable  <= en_nx;
      st.pending <= pd_nx;
      st.active  <= ac_nx;
      st.trig_edge[NIRQ-1:NHALF] <= (st.trig_edge[NIRQ-1:NHALF] & ~cfg_m) | cfg_v;
      if (upd[0].grp_we)         st.group  <= upd[0].grp_d;
      else if (upd[1].grp_we)    st.group  <= upd[1].grp_d;
      if (upd[0].grpmod_we)      st.grpmod <= upd[0].grpmod_d;
      else if (upd[1].grpmod_we) st.grpmod <= upd[1].grpmod_d;
      if (upd[0].nsacr_we)       st.nsacr  <= upd[0].nsacr_d;
      else if (upd[1].nsacr_we)  st.nsacr  <= upd[1].nsacr_d;
      if (upd[0].wake_we || upd[1].wake_we) begin
        st.sleep  <= upd[0].wake_we ? upd[0].wake_d : upd[1].wake_d;
        st.asleep <= upd[0].wake_we ? upd[0].wake_d : upd[1].wake_d;
      end
    end
  end

  for (genvar i = 0; i < NIRQ; i++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        st.prio[PRIO_W*i +: PRIO_W] <= '0;
      else if (upd[0].prio_we[i])
        st.prio[PRIO_W*i +: PRIO_W] <= upd[0].prio_d[PRIO_W*i +: PRIO_W];
      else if (upd[1].prio_we[i])
        st.prio[PRIO_W*i +: PRIO_W] <= upd[1].prio_d[PRIO_W*i +: PRIO_W];
    end
  end

  logic [63:0] rd_nx;
  always_comb begin
    if (req_write)    rd_nx = '0;
    else if (is_byte) rd_nx = {56'd0, 8'(lrdata[0] >> (8 * req_addr[1:0]))};
    else              rd_nx = {lrdata[1], lrdata[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_rdata <= req_valid ? rd_nx : '0;
    end
  end

  assign st_group   = st.group;
  assign st_grpmod  = st.grpmod;
  assign st_nsacr   = st.nsacr;
  assign st_enable  = st.enable;
  assign st_pending = st.pending;
  assign st_active  = st.active;
  assign st_edge    = st.trig_edge;
  assign st_prio    = st.prio;
  assign st_sleep   = st.sleep;
  assign st_asleep  = st.asleep;

endmodule

// File: rtl/pirq_regbank_chk.sv
module pirq_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic        resp_valid,
  input logic [63:0] resp_rdata,
  input logic        wr_fire,
  input logic        ns_view,
  input logic        sec_priv,
  input logic [31:0] st_group,
  input logic [31:0] st_grpmod,
  input logic [31:0] st_nsacr,
  input logic [31:0] st_enable,
  input logic [31:0] st_edge,
  input logic        st_sleep,
  input logic        st_asleep
);

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  assert_write_rdata_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (resp_rdata == 64'd0));

  assert_state_only_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> ($stable(st_enable) && $stable(st_group) && $stable(st_edge)));

  assert_ns_enable_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && ns_view) |=> (((st_enable ^ $past(st_enable)) & ~$past(st_group)) == 32'd0));

  assert_cfg_low_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_edge[15:0] == 16'd0);

  assert_group_ns_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && ns_view) |=> $stable(st_group));

  assert_secure_only_regs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !sec_priv) |=> ($stable(st_grpmod) && $stable(st_nsacr)));

  assert_asleep_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_asleep == st_sleep);

endmodule

bind pirq_regbank pirq_regbank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .resp_valid (resp_valid),
  .resp_rdata (resp_rdata),
  .wr_fire    (wr_fire),
  .ns_view    (ns_view),
  .sec_priv   (sec_priv),
  .st_group   (st_group),
  .st_grpmod  (st_grpmod),
  .st_nsacr   (st_nsacr),
  .st_enable  (st_enable),
  .st_edge    (st_edge),
  .st_sleep   (st_sleep),
  .st_asleep  (st_asleep)
);

// File: tb/pirq_regbank_tb.sv
`timescale 1ns/1ps
module pirq_regbank_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sec_disable = 1'b0;
  logic [31:0]  irq_level = '0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [1:0]   req_size = 2'd1;
  logic [11:0]  req_addr = '0;
  logic [63:0]  req_wdata = '0;
  logic         req_secure = 1'b0;
  logic         resp_valid;
  logic [63:0]  resp_rdata;
  logic [31:0]  st_group, st_grpmod, st_nsacr, st_enable, st_pending, st_active, st_edge;
  logic [255:0] st_prio;
  logic         st_sleep, st_asleep;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  pirq_regbank #(.ADDR_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable), .irq_level(irq_level),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .st_group(st_group), .st_grpmod(st_grpmod), .st_nsacr(st_nsacr),
    .st_enable(st_enable), .st_pending(st_pending), .st_active(st_active),
    .st_edge(st_edge), .st_prio(st_prio), .st_sleep(st_sleep), .st_asleep(st_asleep)
  );

  localparam bit W = 1'b1, R = 1'b0, SEC = 1'b1, NS = 1'b0;
  localparam logic [1:0] B = 2'd0, WD = 2'd1, DW = 2'd2;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one request, expected response pushed to the scoreboard
  task automatic acc(input bit wr, input logic [1:0] sz, input logic [11:0] a,
                     input logic [63:0] d, input bit sec, input logic [63:0] exp,
                     input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = a; req_wdata = d; req_secure = sec;
    exp_q.push_back(wr ? 64'd0 : exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: one cycle after each request the response is compared
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2: actual unexpected response expected none");
      end else begin
        chk(tag_q.pop_front(), resp_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 enable", 64'(st_enable), 0);
    chk("R1 prio", 64'(st_prio[63:0]), 0);
    chk("R1 resp_valid", 64'(resp_valid), 0);
    acc(R, WD, 12'h10, 0, SEC, 0, "R1 group read");

    // R9 group register visibility
    acc(W, WD, 12'h10, 64'hFFFF0000, SEC, 0, "R2 write");
    acc(R, WD, 12'h10, 0, SEC, 64'hFFFF0000, "R9 group secure");
    acc(R, WD, 12'h10, 0, NS, 0, "R9 group ns raz");
    acc(W, WD, 12'h10, 0, NS, 0, "R9 group ns wi");
    acc(R, WD, 12'h10, 0, SEC, 64'hFFFF0000, "R9 group kept");

    // R3/R4 enable set/clear and masking
    acc(W, WD, 12'h20, 64'hFF, SEC, 0, "R3 set");
    acc(W, WD, 12'h20, 64'hFFFFFFFF, NS, 0, "R4 ns set");
    acc(R, WD, 12'h24, 0, SEC, 64'hFFFF00FF, "R3 clr alias read");
    acc(R, WD, 12'h24, 0, NS, 64'hFFFF0000, "R4 ns view");
    acc(W, WD, 12'h24, 64'hFFFFFFFF, NS, 0, "R4 ns clear");
    acc(R, WD, 12'h20, 0, SEC, 64'hFF, "R4 secure bits kept");
    acc(W, WD, 12'h24, 64'h0F, SEC, 0, "R3 clear");
    acc(R, WD, 12'h20, 0, SEC, 64'hF0, "R3 after clear");
    drain();
    chk("R3 st_enable", 64'(st_enable), 64'hF0);
    acc(W, WD, 12'h30, 64'h00030003, NS, 0, "R4 active ns set");
    acc(R, WD, 12'h34, 0, SEC, 64'h00030000, "R4 active masked");

    // R5 pending with level line, R8 trigger config
    irq_level = 32'h0010_0000;
    acc(R, WD, 12'h28, 0, SEC, 64'h00100000, "R5 level pending");
    acc(R, WD, 12'h2C, 0, NS, 64'h00100000, "R5 level pending ns");
    acc(W, WD, 12'h3C, 64'h200, SEC, 0, "R8 set edge");
    drain();
    chk("R8 st_edge", 64'(st_edge), 64'h00100000);
    acc(R, WD, 12'h28, 0, SEC, 0, "R5 edge masks level");
    acc(R, WD, 12'h3C, 0, NS, 64'h200, "R8 cfg read");
    acc(W, WD, 12'h38, 64'hAAAAAAAA, SEC, 0, "R8 cfg lo write");
    acc(R, WD, 12'h38, 0, SEC, 0, "R8 cfg lo ignored");
    acc(W, WD, 12'h10, 64'hFFFE0000, SEC, 0, "R9 group");
    acc(W, WD, 12'h3C, 64'h203, SEC, 0, "R8 cfg hi");
    acc(W, WD, 12'h3C, 0, NS, 0, "R8 ns cfg");
    drain();
    chk("R8 masked edge", 64'(st_edge), 64'h00010000);
    irq_level = '0;
    acc(W, WD, 12'h10, 64'hFFFF0000, SEC, 0, "R9 group");

    // R6/R7 priorities
    acc(W, WD, 12'h40, 64'h44332211, SEC, 0, "R6 write");
    acc(R, B, 12'h42, 0, SEC, 64'h33, "R6 byte read");
    acc(R, WD, 12'h40, 0, SEC, 64'h44332211, "R6 word read");
    acc(W, B, 12'h50, 64'h40, NS, 0, "R7 ns write");
    drain();
    chk("R7 stored", 64'(st_prio[135:128]), 64'hA0);
    acc(R, B, 12'h50, 0, NS, 64'h40, "R7 ns read");
    acc(R, B, 12'h50, 0, SEC, 64'hA0, "R7 secure read");
    acc(W, WD, 12'h40, 64'hFFFFFFFF, NS, 0, "R4 ns prio write");
    acc(R, WD, 12'h40, 0, NS, 0, "R4 ns prio raz");
    acc(R, WD, 12'h40, 0, SEC, 64'h44332211, "R7 secure prio kept");

    // R4/R9 with security disabled
    sec_disable = 1'b1;
    acc(R, WD, 12'h40, 0, NS, 64'h44332211, "R4 sec off");
    acc(R, WD, 12'h10, 0, NS, 64'hFFFF0000, "R9 sec off group");
    acc(W, WD, 12'h14, 64'h5, SEC, 0, "R9 grpmod sec off");
    acc(R, WD, 12'h14, 0, SEC, 0, "R9 grpmod raz");
    sec_disable = 1'b0;
    acc(W, WD, 12'h14, 64'h5, NS, 0, "R9 grpmod ns");
    acc(R, WD, 12'h14, 0, SEC, 0, "R9 grpmod ns ignored");
    acc(W, WD, 12'h14, 64'h5, SEC, 0, "R9 grpmod sec");
    acc(R, WD, 12'h14, 0, SEC, 64'h5, "R9 grpmod stored");
    acc(R, WD, 12'h14, 0, NS, 0, "R9 grpmod ns raz");
    acc(W, WD, 12'h18, 64'hA5A5, SEC, 0, "R9 nsacr");
    acc(R, WD, 12'h18, 0, SEC, 64'hA5A5, "R9 nsacr read");

    // R10 wake
    acc(W, WD, 12'h00, 64'hFFFFFFFF, NS, 0, "R10 sleep");
    acc(R, WD, 12'h00, 0, NS, 64'h3, "R10 read");
    drain();
    chk("R10 asleep", {62'd0, st_asleep, st_sleep}, 64'h3);
    acc(W, WD, 12'h00, 64'h2, SEC, 0, "R10 wake");
    acc(R, WD, 12'h00, 0, SEC, 0, "R10 awake");

    // R11 unimplemented and illegal accesses
    acc(W, WD, 12'h08, 64'hFFFFFFFF, SEC, 0, "R11 write");
    acc(R, WD, 12'h08, 0, SEC, 0, "R11 unimpl read");
    acc(R, B, 12'h20, 0, SEC, 0, "R11 byte non-prio");
    acc(W, B, 12'h20, 64'hFF, SEC, 0, "R11 byte write");
    acc(R, WD, 12'h20, 0, SEC, 64'hF0, "R11 enable kept");
    acc(R, WD, 12'h42, 0, SEC, 0, "R11 misaligned");
    acc(R, 2'd3, 12'h20, 0, SEC, 0, "R11 size3");

    // R12 doubleword, R3 clear-last ordering
    acc(W, DW, 12'h40, 64'h8877665544332211, SEC, 0, "R12 write");
    acc(R, DW, 12'h40, 0, SEC, 64'h8877665544332211, "R12 prio read");
    acc(R, DW, 12'h20, 0, SEC, 64'h000000F0000000F0, "R12 enable pair");
    acc(W, DW, 12'h28, 64'h0000000100000003, SEC, 0, "R3 set+clr");
    acc(R, WD, 12'h28, 0, SEC, 64'h2, "R3 clear last");
    drain();
    chk("R3 st_pending", 64'(st_pending), 64'h2);
    chk("R2 queue empty", 64'(exp_q.size()), 0);
    finish_run();
  end

endmodule